// File: doc/BRIEF.md
# Transfer Length to Command Splitter

This block turns one transfer request (a byte count, a direction and a start strobe) into a short series of data-phase command entries for a serial-flash controller's command queue. A byte count too large for the 8-bit immediate field is cut into power-of-two chunks. Each chunk is coded as an exponent entry. The chunks are taken from the lowest set bit at or above bit 8, working upward. Whatever is left after that, up to 255 bytes, is sent as one direct entry that carries the count itself.

Every entry leaves on a valid/ready interface. An entry is offered only while the downstream command queue reports empty. Alongside each entry the block gives the number of data bytes that entry covers, so that a transmit word feeder can push exactly that much data. Receive requests have their direct remainder rounded up to a whole number of 32-bit words. A one-cycle done pulse closes each request, and an entry counter shows how many entries the current request has produced.

Top module: `xfer_cmd_splitter`

## Requirements
- R1: While the remaining count exceeds 255, the block emits an exponent entry. Bit 9 is set and imm (bits[7:0]) is k, the lowest set bit of the remaining count at position 8 or higher. The reported byte count is 2^k, and 2^k is then subtracted from the remaining count.
- R2: For a transmit request, once the remaining count is 255 or less and non-zero, the block emits one direct entry and the request ends. In that entry bit 9 is clear, and imm and the reported byte count both equal the remaining count. A remaining count of exactly 0 after an exponent entry ends the request with no further entry.
- R3: Every entry has these bits set: bit 8 (data phase), bits[11:10] = 01 (single lane), bit 12 (lower chip select) and bit 14 (lower bus). Bits 13 and 15 are 0. Exactly one of bit 16 (transmit, dir_rx_i = 0) and bit 17 (receive, dir_rx_i = 1) is set.
- R4: For a receive request, the direct remainder r is rounded up to the next multiple of 4, and the reported count equals the rounded value. If the rounded value is 256 (r = 253..255), the block emits an exponent entry with imm = 8 and a count of 256.
- R5: ent_valid_o is high only while a request is in progress and dfifo_empty_i is high.
- R6: An offered entry and its byte count stay unchanged until ent_ready_i accepts them. Each accepted handshake moves the block to the next entry.
- R7: A start with len_i = 0 produces no entry and raises done_o in the next cycle.
- R8: done_o is a single-cycle pulse in the cycle after the last entry is accepted. busy_o is low in that same cycle.
- R9: start_i has no effect while busy_o is high. The request in progress continues unchanged.
- R10: ent_count_o is cleared by an accepted start and rises by one with each accepted entry.
- R11: After reset, busy_o, done_o, ent_valid_o and ent_count_o are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request strobe, taken only while idle |
| dir_rx_i | input | 1 | 1 = receive, 0 = transmit |
| len_i | input | LEN_W | Request length in bytes |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle end-of-request pulse |
| dfifo_empty_i | input | 1 | Downstream command queue is empty |
| ent_valid_o | output | 1 | Entry offered |
| ent_ready_i | input | 1 | Downstream accepts the entry |
| ent_data_o | output | 18 | Command entry |
| ent_bytes_o | output | LEN_W | Data bytes covered by the entry |
| ent_count_o | output | CNT_W | Entries accepted in this request |

## Verification
The assertions assume that ent_ready_i and dfifo_empty_i are driven at every clock edge. They do not assume that either signal is held steady, so both may toggle freely while an entry waits. They also assume that len_i and dir_rx_i only matter in the cycle that start_i is taken. The stimulus drives ready and empty with independent random values on every cycle. It fires extra start strobes with unrelated lengths during busy periods. It mixes random lengths of every bit width with directed counts at the 255/256 boundary and in the receive rounding corner.

// File: rtl/xcs_pkg.sv
package xcs_pkg;

  localparam int IMM_W   = 8;
  localparam int ENTRY_W = 18;

  typedef struct packed {
    logic             rx;
    logic             tx;
    logic             rsv15;
    logic             bus_lo;
    logic             rsv13;
    logic             cs_lo;
    logic [1:0]       lanes;
    logic             expo;
    logic             xfer;
    logic [IMM_W-1:0] imm;
  } entry_t;

  localparam logic [1:0] LANES_SINGLE = 2'b01;

endpackage

// File: rtl/xcs_chunk_pick.sv
module xcs_chunk_pick
  import xcs_pkg::*;
#(
  parameter int LEN_W = 32,
  localparam int K_W  = $clog2(LEN_W)
) (
  input  logic [LEN_W-1:0] rem_i,
  output logic             big_o,
  output logic [K_W-1:0]   k_o
);

  // remainder is above the immediate range when any bit at IMM_W or higher is set
  assign big_o = |rem_i[LEN_W-1:IMM_W];

  // lowest set bit at or above IMM_W; the descending scan leaves the lowest one
  always_comb begin
    k_o = K_W'(IMM_W);
    for (int i = LEN_W - 1; i >= IMM_W; i--) begin
      if (rem_i[i]) k_o = K_W'(i);
    end
  end

endmodule

// File: rtl/xcs_entry_fmt.sv
module xcs_entry_fmt
  import xcs_pkg::*;
#(
  parameter int LEN_W = 32,
  localparam int K_W  = $clog2(LEN_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_en_i,
  input  logic             big_i,
  input  logic [K_W-1:0]   k_i,
  input  logic [IMM_W-1:0] rem_lo_i,
  input  logic             rx_i,
  output entry_t           entry_o,
  output logic [LEN_W-1:0] bytes_o
);

  logic [IMM_W:0] rounded;

  // receive remainder rounded up to a whole word
  assign rounded = ({1'b0, rem_lo_i} + (IMM_W+1)'(3)) & ~(IMM_W+1)'(3);

  always_comb begin
    entry_o        = '0;
    entry_o.xfer   = 1'b1;
    entry_o.lanes  = LANES_SINGLE;
    entry_o.cs_lo  = 1'b1;
    entry_o.bus_lo = 1'b1;
    entry_o.tx     = ~rx_i;
    entry_o.rx     = rx_i;
    if (big_i) begin
      entry_o.expo = 1'b1;
      entry_o.imm  = IMM_W'(k_i);
      bytes_o      = LEN_W'(1) << k_i;
    end else if (rx_i && rounded[IMM_W]) begin
      entry_o.expo = 1'b1;
      entry_o.imm  = IMM_W'(IMM_W);
      bytes_o      = LEN_W'(1) << IMM_W;
    end else if (rx_i) begin
      entry_o.imm  = rounded[IMM_W-1:0];
      bytes_o      = LEN_W'(rounded);
    end else begin
      entry_o.imm  = rem_lo_i;
      bytes_o      = LEN_W'(rem_lo_i);
    end
  end

  // R4: a direct receive entry is always word sized
  assert_rx_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && entry_o.rx && !entry_o.expo) |-> (entry_o.imm[1:0] == 2'b00));

  // R1: an exponent entry never codes a chunk smaller than the immediate range
  assert_exp_min_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_en_i && entry_o.expo) |-> (entry_o.imm >= IMM_W'(IMM_W)));

  // R3: direction bits are exclusive
  assert_dir_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    chk_en_i |-> ($countones({entry_o.rx, entry_o.tx}) == 1));

endmodule

// File: rtl/xfer_cmd_splitter.sv
module xfer_cmd_splitter
  import xcs_pkg::*;
#(
  parameter int LEN_W  = 32,
  localparam int K_W   = $clog2(LEN_W),
  localparam int CNT_W = $clog2(LEN_W - IMM_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               dir_rx_i,
  input  logic [LEN_W-1:0]   len_i,
  output logic               busy_o,
  output logic               done_o,
  input  logic               dfifo_empty_i,
  output logic               ent_valid_o,
  input  logic               ent_ready_i,
  output logic [ENTRY_W-1:0] ent_data_o,
  output logic [LEN_W-1:0]   ent_bytes_o,
  output logic [CNT_W-1:0]   ent_count_o
);

  typedef enum logic {ST_IDLE, ST_EMIT} state_t;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  state_t           state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             rx_q, rx_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic             big;
  logic [K_W-1:0]   k;
  entry_t           entry;
  logic [LEN_W-1:0] bytes;
  logic             fire;
  logic             last;

  xcs_chunk_pick #(.LEN_W(LEN_W)) u_pick (
    .rem_i (rem_q),
    .big_o (big),
    .k_o   (k)
  );

  xcs_entry_fmt #(.LEN_W(LEN_W)) u_fmt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .chk_en_i (ent_valid_o),
    .big_i    (big),
    .k_i      (k),
    .rem_lo_i (rem_q[IMM_W-1:0]),
    .rx_i     (rx_q),
    .entry_o  (entry),
    .bytes_o  (bytes)
  );

  assign ent_valid_o = (state_q == ST_EMIT) && dfifo_empty_i;
  assign fire        = ent_valid_o && ent_ready_i;
  assign last        = !big || (rem_q == bytes);

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    rx_d    = rx_q;
    done_d  = 1'b0;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          rx_d  = dir_rx_i;
          rem_d = len_i;
          cnt_d = '0;
          if (len_i == '0) done_d  = 1'b1;
          else             state_d = ST_EMIT;
        end
      end
      ST_EMIT: begin
        if (fire) begin
          cnt_d = cnt_q + CNT_W'(1);
          if (last) begin
            rem_d   = '0;
            state_d = ST_IDLE;
            done_d  = 1'b1;
          end else begin
            rem_d = rem_q - bytes;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      rx_q    <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      rx_q    <= rx_d;
      done_q  <= done_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o      = (state_q == ST_EMIT);
  assign done_o      = done_q;
  assign ent_data_o  = entry;
  assign ent_bytes_o = bytes;
  assign ent_count_o = cnt_q;

  // R6: a stalled entry holds its contents
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ent_valid_o && !ent_ready_i) |=> ($stable(ent_data_o) && $stable(ent_bytes_o)));

  // R8: done lasts a single cycle and follows the final accept
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |=> !done_o);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_o |-> !busy_o);

  // R7: an empty request completes without emitting
  assert_zero_len_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (start_i && !busy_o && (len_i == '0)) |=> (done_o && !busy_o && !ent_valid_o));

  // R9: a start while busy leaves the entry count alone
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy_o && start_i && !fire) |=> $stable(ent_count_o));

  // R10: each accepted entry advances the count by one
  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    fire |=> (ent_count_o == $past(ent_count_o) + CNT_W'(1)));

  // R5: nothing is offered outside a request
  assert_valid_busy_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    ent_valid_o |-> busy_o);

endmodule

// File: tb/tb_xfer_cmd_splitter.sv
module tb_xfer_cmd_splitter;

  localparam int LEN_W = 32;
  localparam int CNT_W = 5;

  logic             clk;
  logic             rst_n;
  logic             start_i;
  logic             dir_rx_i;
  logic [LEN_W-1:0] len_i;
  logic             busy_o;
  logic             done_o;
  logic             dfifo_empty_i;
  logic             ent_valid_o;
  logic             ent_ready_i;
  logic [17:0]      ent_data_o;
  logic [LEN_W-1:0] ent_bytes_o;
  logic [CNT_W-1:0] ent_count_o;

  int n_chk;
  int n_bad;

  xfer_cmd_splitter #(.LEN_W(LEN_W)) dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .dir_rx_i      (dir_rx_i),
    .len_i         (len_i),
    .busy_o        (busy_o),
    .done_o        (done_o),
    .dfifo_empty_i (dfifo_empty_i),
    .ent_valid_o   (ent_valid_o),
    .ent_ready_i   (ent_ready_i),
    .ent_data_o    (ent_data_o),
    .ent_bytes_o   (ent_bytes_o),
    .ent_count_o   (ent_count_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [17:0] tmpl(input bit rx);
    logic [17:0] t;
    t = 18'h0;
    t[8]     = 1'b1;
    t[11:10] = 2'b01;
    t[12]    = 1'b1;
    t[14]    = 1'b1;
    if (rx) t[17] = 1'b1;
    else    t[16] = 1'b1;
    return t;
  endfunction

  // expected entry for a remaining count, per R1..R4
  function automatic void model(input logic [LEN_W-1:0] rem, input bit rx,
                                output logic [17:0] ent, output logic [LEN_W-1:0] nb,
                                output logic [LEN_W-1:0] rem_after);
    int k;
    int r;
    ent = tmpl(rx);
    if (rem > 255) begin
      k = 8;
      while (!rem[k]) k++;
      ent[9]   = 1'b1;
      ent[7:0] = 8'(k);
      nb = LEN_W'(1) << k;
      rem_after = rem - nb;
    end else begin
      r = int'(rem);
      if (rx) r = (r + 3) & ~3;
      if (r == 256) begin
        ent[9]   = 1'b1;
        ent[7:0] = 8'd8;
      end else begin
        ent[7:0] = 8'(r);
      end
      nb = LEN_W'(r);
      rem_after = '0;
    end
  endfunction

  task automatic run(input logic [LEN_W-1:0] len, input bit rx, input bit inject,
                     input int rdy_pct);
    logic [17:0]      e_ent [32];
    logic [LEN_W-1:0] e_nb  [32];
    logic [LEN_W-1:0] rem;
    logic [LEN_W-1:0] nxt;
    int n;
    int idx;
    bit pend_done;
    bit got_done;
    bit held;
    logic [17:0] held_ent;
    n = 0;
    rem = len;
    while (rem != 0 && n < 32) begin
      model(rem, rx, e_ent[n], e_nb[n], nxt);
      rem = nxt;
      n++;
    end
    @(negedge clk);
    start_i       = 1'b1;
    dir_rx_i      = rx;
    len_i         = len;
    ent_ready_i   = 1'b0;
    dfifo_empty_i = 1'b0;
    idx       = 0;
    pend_done = (len == 0);
    got_done  = 1'b0;
    held      = 1'b0;
    held_ent  = '0;
    for (int it = 0; it < 4000; it++) begin
      @(negedge clk);
      ent_ready_i   = (($urandom % 100) < rdy_pct);
      dfifo_empty_i = (($urandom % 4) != 0);
      if (inject && busy_o && (it % 3 == 1)) begin
        start_i  = 1'b1;
        len_i    = $urandom;
        dir_rx_i = ~rx;
      end else begin
        start_i  = 1'b0;
      end
      #1;
      got_done = done_o;
      if (got_done || pend_done) begin
        check(got_done == pend_done, "R8 done after last accept (R7 for zero length)",
              64'(got_done), 64'(pend_done));
        check(!busy_o, "R8 busy low with done", 64'(busy_o), 64'h0);
        break;
      end
      if (!dfifo_empty_i)
        check(!ent_valid_o, "R5 no entry while queue not empty", 64'(ent_valid_o), 64'h0);
      if (held && ent_valid_o)
        check(ent_data_o == held_ent, "R6 stalled entry held", 64'(ent_data_o),
              64'(held_ent));
      held = 1'b0;
      if (ent_valid_o && ent_ready_i) begin
        if (idx >= n) begin
          check(1'b0, "R2 extra entry", 64'(idx), 64'(n));
        end else begin
          check(ent_data_o == e_ent[idx], "R1/R2/R3/R4 entry", 64'(ent_data_o),
                64'(e_ent[idx]));
          check(ent_bytes_o == e_nb[idx], "R1/R2/R4 byte count", 64'(ent_bytes_o),
                64'(e_nb[idx]));
        end
        idx++;
        if (idx == n) pend_done = 1'b1;
      end else if (ent_valid_o) begin
        held     = 1'b1;
        held_ent = ent_data_o;
      end
    end
    check(got_done, "R8 request completed", 64'(got_done), 64'h1);
    check(idx == n, "R1 entry total (R9 start while busy ignored)", 64'(idx), 64'(n));
    check(ent_count_o == CNT_W'(n), "R10 entry counter", 64'(ent_count_o), 64'(n));
    start_i = 1'b0;
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run hung, got 0x0 expected 0x1");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int w;
    logic [LEN_W-1:0] rl;
    void'($urandom(32'h5eed_0042));
    rst_n         = 1'b0;
    start_i       = 1'b0;
    dir_rx_i      = 1'b0;
    len_i         = '0;
    dfifo_empty_i = 1'b1;
    ent_ready_i   = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    check(!busy_o, "R11 reset busy", 64'(busy_o), 64'h0);
    check(!done_o, "R11 reset done", 64'(done_o), 64'h0);
    check(!ent_valid_o, "R11 reset valid", 64'(ent_valid_o), 64'h0);
    check(ent_count_o == '0, "R11 reset count", 64'(ent_count_o), 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    run(32'd0,          1'b0, 1'b0, 70);
    run(32'd1,          1'b0, 1'b0, 70);
    run(32'd255,        1'b0, 1'b0, 70);
    run(32'd256,        1'b0, 1'b0, 70);
    run(32'd257,        1'b0, 1'b1, 50);
    run(32'hFFFF_FFFF,  1'b0, 1'b1, 60);
    run(32'h8000_0000,  1'b1, 1'b0, 60);
    run(32'd253,        1'b1, 1'b0, 70);
    run(32'd254,        1'b1, 1'b0, 70);
    run(32'd5,          1'b1, 1'b0, 70);
    run(32'd4,          1'b1, 1'b0, 70);
    run(32'h1FD,        1'b1, 1'b1, 40);
    run(32'd0,          1'b1, 1'b0, 70);
    run(32'h0001_2301,  1'b0, 1'b0, 30);

    // random lengths of every width
    for (int t = 0; t < 60; t++) begin
      w  = int'($urandom % 33);
      rl = $urandom;
      if (w < 32) rl = rl & ((LEN_W'(1) << w) - LEN_W'(1));
      run(rl, 1'($urandom % 2), 1'($urandom % 2), 20 + int'($urandom % 80));
    end

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule